// File: doc/BRIEF.md
# Banked Stack Pointer Selector

This block keeps the two stack pointers of a processor core, one for the main stack and one for the process stack, and decides which of them stands behind register 13. The register file sends its register-13 reads and writes here. The core supplies a flag that says whether it runs in Handler mode or Thread mode. A write path from the move-to-special-register operation and the value a handler supplies on exception return both set a single stack-select bit.

In Handler mode the main pointer is always the one in use. In Thread mode the stack-select bit picks the pointer. Every value written to a pointer loses its two least significant bits, so both pointers always hold word-aligned addresses. After reset the main pointer is loaded from a boot value input and the process pointer starts at zero. Exception entry forces the select bit back to main. Exception return sets the select bit again from the return value.

Top module: `sp_bank`

## Requirements
- R1: While reset is asserted, `sp_rd_data` and `ctrl_rd_data` read zero and the select bit is 0. On the first clock edge after reset is released, the main pointer loads `boot_sp` with bits [1:0] cleared. The process pointer resets to zero.
- R2: A register-13 write (`sp_wr_en`) stores `sp_wr_data` with bits [1:0] forced to 0 into the pointer that is in use. The new value reads back from the next cycle.
- R3: While `in_handler` is 1, `sp_rd_data` shows the main pointer and register-13 writes go to the main pointer, whatever the select bit holds.
- R4: While `in_handler` is 0, select bit 0 exposes the main pointer and select bit 1 exposes the process pointer, for both reads and writes.
- R5: A control write (`ctrl_wr_en`) in Thread mode loads the select bit from `ctrl_wr_data` bit 1 and takes effect in the next cycle. In Handler mode a control write leaves the select bit unchanged.
- R6: `ctrl_rd_data` carries the select bit in bit 1, and every other bit reads 0.
- R7: `exc_entry` clears the select bit.
- R8: `exc_return` sets the select bit to 1 only when `exc_ret_value` bit 3 (return to Thread) and bit 2 (use the process stack) are both 1. Otherwise it sets the select bit to 0.
- R9: When several select-bit sources fall in the same cycle, `exc_entry` wins over `exc_return`, and `exc_return` wins over a control write.
- R10: A register-13 write in the same cycle as a change of the select bit goes to the pointer that was in use before that clock edge.
- R11: The pointer that is not written keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sp | input | 32 | Initial main stack pointer value |
| in_handler | input | 1 | 1 = Handler mode, 0 = Thread mode |
| sp_wr_en | input | 1 | Register-13 write strobe |
| sp_wr_data | input | 32 | Register-13 write value |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | 32 | Control register write value (bit 1 = stack select) |
| exc_entry | input | 1 | Exception entry event |
| exc_return | input | 1 | Exception return event |
| exc_ret_value | input | 32 | Return value supplied by the handler |
| sp_rd_data | output | 32 | Register-13 read value |
| ctrl_rd_data | output | 32 | Control register read value |

## Verification
A register-13 write can land in the same cycle as a change of the stack-select bit, whether that change comes from a control write, an exception entry or an exception return. The directed part of the bench provokes this by issuing a process-pointer write together with a control write that switches back to main. It then reads both pointers in later cycles to confirm that the write went to the pointer selected before the edge. A long random sweep drives every strobe independently, so all three select sources and the pointer writes collide in many combinations. An arithmetic model judges each cycle on the outputs.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_CTRL  = 2'd1,
    SRC_RET   = 2'd2,
    SRC_ENTRY = 2'd3
  } sel_src_e;

  localparam int unsigned BANK_MAIN = 0;
  localparam int unsigned BANK_PROC = 1;
  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/sp_word_reg.sv
module sp_word_reg #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] q
);
  localparam int unsigned HI_W = DATA_W - ALIGN_BITS;

  logic [HI_W-1:0] hi_q;
  logic [HI_W-1:0] hi_d;
  logic            unused_low;

  assign unused_low = ^load_val[ALIGN_BITS-1:0];

  always_comb begin
    hi_d = hi_q;
    if (load_en) begin
      hi_d = load_val[DATA_W-1:ALIGN_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else begin
      hi_q <= hi_d;
    end
  end

  assign q = {hi_q, {ALIGN_BITS{1'b0}}};

  // R11
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(q));
endmodule

// File: rtl/sp_sel_ctrl.sv
module sp_sel_ctrl
  import sp_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_handler,
  input  logic ctrl_wr_en,
  input  logic ctrl_sel_in,
  input  logic exc_entry,
  input  logic exc_return,
  input  logic ret_to_thread,
  input  logic ret_use_proc,
  output logic sel
);
  sel_src_e src;
  logic     sel_d;

  always_comb begin
    if (exc_entry) begin
      src = SRC_ENTRY;
    end else if (exc_return) begin
      src = SRC_RET;
    end else if (ctrl_wr_en && !in_handler) begin
      src = SRC_CTRL;
    end else begin
      src = SRC_HOLD;
    end
  end

  always_comb begin
    case (src)
      SRC_ENTRY: sel_d = 1'b0;
      SRC_RET:   sel_d = ret_to_thread & ret_use_proc;
      SRC_CTRL:  sel_d = ctrl_sel_in;
      default:   sel_d = sel;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= 1'b0;
    end else begin
      sel <= sel_d;
    end
  end

  // R7
  entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> !sel);

  // R5
  handler_ctrl_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_en && in_handler && !exc_entry && !exc_return) |=> $stable(sel));

  // R8
  ret_process_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_entry && ret_to_thread && ret_use_proc) |=> sel);
endmodule

// File: rtl/sp_bank.sv
module sp_bank
  import sp_bank_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned ALIGN_BITS    = 2,
  parameter int unsigned CTRL_SEL_BIT  = 1,
  parameter int unsigned RET_STACK_BIT = 2,
  parameter int unsigned RET_MODE_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] boot_sp,
  input  logic              in_handler,
  input  logic              sp_wr_en,
  input  logic [DATA_W-1:0] sp_wr_data,
  input  logic              ctrl_wr_en,
  input  logic [DATA_W-1:0] ctrl_wr_data,
  input  logic              exc_entry,
  input  logic              exc_return,
  input  logic [DATA_W-1:0] exc_ret_value,
  output logic [DATA_W-1:0] sp_rd_data,
  output logic [DATA_W-1:0] ctrl_rd_data
);
  localparam int unsigned HI_W = DATA_W - ALIGN_BITS;

  logic              boot_pend;
  logic              boot_pend_d;
  logic              sel;
  logic              use_proc;
  logic [NUM_BANKS-1:0]             bank_load;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_val;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;
  logic              unused_in;

  assign unused_in = ^{ctrl_wr_data, exc_ret_value};

  // Boot load happens on the first edge after reset release
  always_comb begin
    boot_pend_d = boot_pend;
    if (boot_pend) begin
      boot_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_pend <= 1'b1;
    end else begin
      boot_pend <= boot_pend_d;
    end
  end

  sp_sel_ctrl u_sel (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_handler    (in_handler),
    .ctrl_wr_en    (ctrl_wr_en),
    .ctrl_sel_in   (ctrl_wr_data[CTRL_SEL_BIT]),
    .exc_entry     (exc_entry),
    .exc_return    (exc_return),
    .ret_to_thread (exc_ret_value[RET_MODE_BIT]),
    .ret_use_proc  (exc_ret_value[RET_STACK_BIT]),
    .sel           (sel)
  );

  assign use_proc = !in_handler && sel;

  always_comb begin
    bank_load[BANK_MAIN] = boot_pend || (sp_wr_en && !use_proc);
    bank_val[BANK_MAIN]  = boot_pend ? boot_sp : sp_wr_data;
    bank_load[BANK_PROC] = sp_wr_en && use_proc;
    bank_val[BANK_PROC]  = sp_wr_data;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sp_word_reg #(
      .DATA_W     (DATA_W),
      .ALIGN_BITS (ALIGN_BITS)
    ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (bank_load[b]),
      .load_val (bank_val[b]),
      .q        (bank_q[b])
    );
  end

  assign sp_rd_data   = use_proc ? bank_q[BANK_PROC] : bank_q[BANK_MAIN];
  assign ctrl_rd_data = DATA_W'(sel) << CTRL_SEL_BIT;

  // R1
  boot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_pend |=> bank_q[BANK_MAIN] == {$past(boot_sp[DATA_W-1:ALIGN_BITS]), {ALIGN_BITS{1'b0}}});

  // R3
  handler_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr_en && in_handler && !boot_pend) |=>
      bank_q[BANK_MAIN] == {$past(sp_wr_data[DATA_W-1:ALIGN_BITS]), {ALIGN_BITS{1'b0}}});

  // R2
  bank_hi_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr_en && !boot_pend) |=> sp_rd_data[ALIGN_BITS-1:0] == '0);

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: tb/test_sp_bank.sv
`timescale 1ns/1ps
module test_sp_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] boot_sp;
  logic        in_handler, sp_wr_en, ctrl_wr_en, exc_entry, exc_return;
  logic [31:0] sp_wr_data, ctrl_wr_data, exc_ret_value;
  logic [31:0] sp_rd_data, ctrl_rd_data;

  int vectors = 0;
  int errors  = 0;

  logic [31:0] m_main, m_psp;
  logic        m_sel, m_boot;

  always #4 clk = ~clk;

  sp_bank i_sp_bank (
    .clk(clk), .rst_n(rst_n), .boot_sp(boot_sp), .in_handler(in_handler),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .ctrl_wr_en(ctrl_wr_en),
    .ctrl_wr_data(ctrl_wr_data), .exc_entry(exc_entry), .exc_return(exc_return),
    .exc_ret_value(exc_ret_value), .sp_rd_data(sp_rd_data), .ctrl_rd_data(ctrl_rd_data)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic hnd, input logic swe, input logic [31:0] swd,
                       input logic cwe, input logic [31:0] cwd,
                       input logic ent, input logic ret, input logic [31:0] rv,
                       input string tag);
    logic use_p;
    @(negedge clk);
    in_handler = hnd; sp_wr_en = swe; sp_wr_data = swd;
    ctrl_wr_en = cwe; ctrl_wr_data = cwd;
    exc_entry = ent; exc_return = ret; exc_ret_value = rv;
    @(posedge clk);
    use_p = !hnd && m_sel;
    if (m_boot) m_main = boot_sp & ~32'h3;
    else if (swe && !use_p) m_main = swd & ~32'h3;
    if (swe && use_p) m_psp = swd & ~32'h3;
    m_boot = 1'b0;
    if (ent) m_sel = 1'b0;
    else if (ret) m_sel = rv[3] & rv[2];
    else if (cwe && !hnd) m_sel = cwd[1];
    #1;
    chk(sp_rd_data, (!hnd && m_sel) ? m_psp : m_main, tag);
    chk(ctrl_rd_data, {30'd0, m_sel, 1'b0}, "R6");
  endtask

  task automatic idle(input logic hnd, input string tag);
    cycle(hnd, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; boot_sp = 32'h2000_0FFF;
    in_handler = 1'b0; sp_wr_en = 1'b0; sp_wr_data = '0; ctrl_wr_en = 1'b0;
    ctrl_wr_data = '0; exc_entry = 1'b0; exc_return = 1'b0; exc_ret_value = '0;
    m_main = '0; m_psp = '0; m_sel = 1'b0; m_boot = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(sp_rd_data, 32'h0, "R1");
    chk(ctrl_rd_data, 32'h0, "R1");
    @(negedge clk); rst_n = 1'b1;
    idle(1'b0, "R1");
    chk(sp_rd_data, 32'h2000_0FFC, "R1");

    cycle(0, 1, 32'h1234_5677, 0, 0, 0, 0, 0, "R2");
    chk(sp_rd_data, 32'h1234_5674, "R2");
    cycle(0, 0, 0, 1, 32'h2, 0, 0, 0, "R5");
    chk(sp_rd_data, 32'h0, "R4");
    cycle(0, 1, 32'hABCD_0003, 0, 0, 0, 0, 0, "R4");
    chk(sp_rd_data, 32'hABCD_0000, "R4");
    idle(1'b1, "R3");
    chk(sp_rd_data, 32'h1234_5674, "R3");
    cycle(1, 1, 32'h5555_5555, 0, 0, 0, 0, 0, "R3");
    chk(sp_rd_data, 32'h5555_5554, "R3");
    cycle(1, 0, 0, 1, 32'h0, 0, 0, 0, "R5");
    chk(ctrl_rd_data, 32'h2, "R5");
    idle(1'b0, "R11");
    chk(sp_rd_data, 32'hABCD_0000, "R11");
    cycle(1, 0, 0, 0, 0, 1, 0, 0, "R7");
    chk(ctrl_rd_data, 32'h0, "R7");
    cycle(1, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFD, "R8");
    chk(ctrl_rd_data, 32'h2, "R8");
    cycle(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFF9, "R8");
    chk(ctrl_rd_data, 32'h0, "R8");
    cycle(0, 0, 0, 1, 32'h2, 0, 0, 0, "R5");
    cycle(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFF5, "R8");
    chk(ctrl_rd_data, 32'h0, "R8");
    cycle(0, 0, 0, 1, 32'h2, 1, 1, 32'hFFFF_FFFD, "R9");
    chk(ctrl_rd_data, 32'h0, "R9");
    cycle(0, 0, 0, 1, 32'h0, 0, 1, 32'hFFFF_FFFD, "R9");
    chk(ctrl_rd_data, 32'h2, "R9");
    // R10: write lands in process pointer while select switches to main
    cycle(0, 1, 32'h7777_7777, 1, 32'h0, 0, 0, 0, "R10");
    chk(sp_rd_data, 32'h5555_5554, "R10");
    cycle(0, 0, 0, 1, 32'h2, 0, 0, 0, "R10");
    chk(sp_rd_data, 32'h7777_7774, "R10");

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rv;
      logic        h;
      case ($urandom % 4)
        0: rv = 32'hFFFF_FFFD;
        1: rv = 32'hFFFF_FFF9;
        2: rv = 32'hFFFF_FFF1;
        default: rv = $urandom;
      endcase
      h = 1'($urandom);
      cycle(h, 1'($urandom), $urandom, 1'($urandom), $urandom,
            (($urandom % 8) == 0), (($urandom % 4) == 0), rv,
            h ? "R3" : "R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule